// File: doc/BRIEF.md
# Dual-Channel UART Host Register Interface

This block is the processor-facing front end of a two-channel UART. A host reaches either channel through an active-low chip select for that channel, a 3-bit register address and active-low read and write strobes. The strobes are brought into the system clock domain, and each falling edge acts exactly once. A read drives an 8-bit value out with an output enable for the shared bus. A write loads a register in every selected channel. Each channel keeps its own interrupt-enable, line-control, modem-control and scratch registers, as well as the FIFO-control fields that concern the host side.

From those registers and from status inputs supplied by the rest of the UART, each channel produces several outputs. These are an interrupt line with its own drive enable, a general-purpose output whose level is the inverse of that drive enable, and an active-low receive-ready flag for a DMA engine. The receive-ready flag follows single-transfer rules or block-transfer rules depending on the programmed mode. Reading the receive data slot produces a one-cycle pop pulse toward the receive FIFO. Writing the transmit data slot produces a one-cycle push pulse together with the written byte.

Top module: `dual_uart_hostif`

## Requirements
- R1: A strobe reaches only the channels whose bit in `csN` is 0. A write while `csN` is all ones changes no register, and a write with one channel selected leaves the other channel's registers unchanged.
- R2: Register slots by address. 0: a read returns `rxByte` and a write pushes to transmit. 1: interrupt enables, bits 3:0 stored and bits 7:4 read as 0. 2: a read returns the interrupt identity and a write sets FIFO control. 3: line control, all 8 bits. 4: modem control, bits 4:0 stored. 5 and 6: read as 0 and ignore writes. 7: scratch, all 8 bits.
- R3: `busOe` is 1 only while `rdN` is 0 and at least one `csN` bit is 0. `busOut` then carries the addressed register of the lowest-numbered selected channel.
- R4: For each channel, `irqOe` equals modem-control bit 3 and `op2Out` equals its inverse.
- R5: `irqOut` of a channel is 1 only when modem-control bit 3 is 1 and some condition bit i is 1 together with enable bit i. Condition bits per channel: 0 receive data available, 1 transmit holding empty, 2 receiver error, 3 modem status change.
- R6: Interrupt identity read value, low nibble, in priority order: receiver error 0x06, receive data 0x04, transmit empty 0x02, modem status 0x00, and 0x01 when nothing enabled is pending. Bits 7:4 read as 0.
- R7: With FIFO-control bit 3 at 0, `rxRdyN` is 0 exactly when the channel's `rxLevel` is at least 1.
- R8: With FIFO-control bit 3 at 1, the trigger is taken from FIFO-control bits 7:6 (00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14). `rxRdyN` falls once `rxLevel` reaches the trigger, stays 0 while the level is above 0, and returns to 1 when the level is 0.
- R9: Each falling edge of `rdN` or `wrN` acts once, within four clocks. A read of slot 0 gives exactly one one-clock `rxPop` pulse, and a write of slot 0 gives exactly one one-clock `txPush` pulse with `txByte` holding the written byte.
- R10: Reset (`rst` high) clears every register. Afterwards `irqOe` is 0, `op2Out` is all ones, `irqOut` is 0 and the receive-ready rule is single-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | NUM_CH | Per-channel select, active low |
| regAddr | input | 3 | Register slot address |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| busIn | input | 8 | Host write data |
| busOut | output | 8 | Host read data |
| busOe | output | 1 | Drive enable for the shared data bus |
| rxByte | input | NUM_CH*8 | Head byte of each receive FIFO |
| rxLevel | input | NUM_CH*LVL_W | Fill level of each receive FIFO |
| intCond | input | NUM_CH*4 | Interrupt source conditions per channel |
| irqOut | output | NUM_CH | Interrupt line value per channel |
| irqOe | output | NUM_CH | Interrupt line drive enable per channel |
| op2Out | output | NUM_CH | General-purpose output per channel |
| rxRdyN | output | NUM_CH | Receive-ready flag, active low |
| rxPop | output | NUM_CH | One-clock receive FIFO pop pulse |
| txPush | output | NUM_CH | One-clock transmit FIFO push pulse |
| txByte | output | 8 | Byte accompanying a push |

## Verification
The bench goes after the block-transfer hysteresis of receive-ready. If a design compared only against the trigger, it would release the flag while the level sits between one and the trigger. If it compared only against "not empty", it would assert the flag before the trigger is reached. The bench also counts pop and push pulses across a whole strobe: a design that acted on the strobe level instead of its edge would pop the receive FIFO several times per read. Further targets are the interrupt identity priority with several sources pending at once, writes with no chip select or to the two read-only slots, and the shared meaning of modem-control bit 3. A wrong design there would leave the interrupt line driven while the general-purpose output also reads 0.

// File: rtl/dual_uart_pkg.sv
package dual_uart_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int BYTE_W     = 8;
  localparam int COND_W     = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    SLOT_DATA    = 3'd0,
    SLOT_IEN     = 3'd1,
    SLOT_IDENT   = 3'd2,
    SLOT_LINE    = 3'd3,
    SLOT_MODEM   = 3'd4,
    SLOT_LSTAT   = 3'd5,
    SLOT_MSTAT   = 3'd6,
    SLOT_SCRATCH = 3'd7
  } regSlot_e;

  // Per-channel strobe bundle from bus control to channel datapath
  typedef struct packed {
    logic                  wrFire;
    logic                  rdFire;
    logic [REG_ADDR_W-1:0] regAddr;
    logic [BYTE_W-1:0]     wrData;
  } busStrobe_t;
endpackage

// File: rtl/uart_bus_ctrl.sv
module uart_bus_ctrl
  import dual_uart_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int SYNC_ST = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CH-1:0]            csN,
  input  logic [REG_ADDR_W-1:0]        regAddr,
  input  logic                         rdN,
  input  logic                         wrN,
  input  logic [BYTE_W-1:0]            busIn,
  output busStrobe_t [NUM_CH-1:0]      chStrobe
);
  localparam int PIPE_W = SYNC_ST + 1;

  logic [PIPE_W-1:0] rdPipe;
  logic [PIPE_W-1:0] wrPipe;
  logic              rdFall;
  logic              wrFall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPipe <= '1;
      wrPipe <= '1;
    end else begin
      rdPipe <= {rdPipe[PIPE_W-2:0], rdN};
      wrPipe <= {wrPipe[PIPE_W-2:0], wrN};
    end
  end

  // Falling edge seen after the synchroniser stages
  assign rdFall = rdPipe[PIPE_W-1] & ~rdPipe[PIPE_W-2];
  assign wrFall = wrPipe[PIPE_W-1] & ~wrPipe[PIPE_W-2];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_strobe
    always_comb begin
      chStrobe[ch].rdFire  = rdFall & ~csN[ch];
      chStrobe[ch].wrFire  = wrFall & ~csN[ch];
      chStrobe[ch].regAddr = regAddr;
      chStrobe[ch].wrData  = busIn;
    end
  end

  AST_READ_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rdFall |=> !rdFall); // R9
  AST_WRITE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    wrFall |=> !wrFall); // R9
endmodule

// File: rtl/uart_rx_ready.sv
module uart_rx_ready #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             dmaBlock,
  input  logic [1:0]       trigSel,
  output logic             rxRdyN
);
  logic [LVL_W-1:0] trigVal;
  logic             blockAct;
  logic             blockHeld;
  logic             notEmpty;

  always_comb begin
    unique case (trigSel)
      2'd0:    trigVal = LVL_W'(1);
      2'd1:    trigVal = LVL_W'(4);
      2'd2:    trigVal = LVL_W'(8);
      default: trigVal = LVL_W'(14);
    endcase
  end

  assign notEmpty = (rxLevel != '0);
  assign blockAct = (rxLevel >= trigVal) | (blockHeld & notEmpty);

  always_ff @(posedge clk) begin
    if (rst) blockHeld <= 1'b0;
    else     blockHeld <= blockAct;
  end

  assign rxRdyN = dmaBlock ? ~blockAct : ~notEmpty;

  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rxLevel == '0) |-> rxRdyN); // R8
  AST_WAIT_FOR_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    (dmaBlock && !$past(blockAct) && rxLevel < trigVal) |-> rxRdyN); // R8
  AST_SINGLE_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!dmaBlock && notEmpty) |-> !rxRdyN); // R7
endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import dual_uart_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  busStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic [COND_W-1:0]  intCond,
  output logic [BYTE_W-1:0]  rdData,
  output logic               irqOut,
  output logic               irqOe,
  output logic               op2Out,
  output logic               rxPop,
  output logic               txPush,
  output logic               dmaBlock,
  output logic [1:0]         trigSel
);
  logic [COND_W-1:0] ienReg;
  logic [BYTE_W-1:0] lineReg;
  logic [4:0]        modemReg;
  logic [BYTE_W-1:0] scratchReg;
  logic              fcrBlock;
  logic [1:0]        fcrTrig;
  logic [COND_W-1:0] pending;
  logic [3:0]        identCode;
  logic              wrHit;

  assign wrHit = strobe.wrFire;

  always_ff @(posedge clk) begin
    if (rst) begin
      ienReg     <= '0;
      lineReg    <= '0;
      modemReg   <= '0;
      scratchReg <= '0;
      fcrBlock   <= 1'b0;
      fcrTrig    <= 2'b00;
    end else if (wrHit) begin
      unique case (regSlot_e'(strobe.regAddr))
        SLOT_IEN:     ienReg     <= strobe.wrData[COND_W-1:0];
        SLOT_IDENT: begin
          fcrBlock <= strobe.wrData[3];
          fcrTrig  <= strobe.wrData[7:6];
        end
        SLOT_LINE:    lineReg    <= strobe.wrData;
        SLOT_MODEM:   modemReg   <= strobe.wrData[4:0];
        SLOT_SCRATCH: scratchReg <= strobe.wrData;
        default: ;
      endcase
    end
  end

  assign pending = ienReg & intCond;

  // Priority: line error, rx data, tx empty, modem status
  always_comb begin
    if (pending[2])      identCode = 4'h6;
    else if (pending[0]) identCode = 4'h4;
    else if (pending[1]) identCode = 4'h2;
    else if (pending[3]) identCode = 4'h0;
    else                 identCode = 4'h1;
  end

  always_comb begin
    unique case (regSlot_e'(strobe.regAddr))
      SLOT_DATA:    rdData = rxByte;
      SLOT_IEN:     rdData = {4'h0, ienReg};
      SLOT_IDENT:   rdData = {4'h0, identCode};
      SLOT_LINE:    rdData = lineReg;
      SLOT_MODEM:   rdData = {3'b000, modemReg};
      SLOT_SCRATCH: rdData = scratchReg;
      default:      rdData = '0;
    endcase
  end

  assign irqOe    = modemReg[3];
  assign op2Out   = ~modemReg[3];
  assign irqOut   = modemReg[3] & (|pending);
  assign rxPop    = strobe.rdFire & (strobe.regAddr == SLOT_DATA);
  assign txPush   = strobe.wrFire & (strobe.regAddr == SLOT_DATA);
  assign dmaBlock = fcrBlock;
  assign trigSel  = fcrTrig;

  AST_MODEM_BIT_TO_OE: assert property (@(posedge clk) disable iff (rst)
    (wrHit && strobe.regAddr == SLOT_MODEM) |=> (irqOe == $past(strobe.wrData[3]))); // R4
  AST_IRQ_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !irqOe |-> !irqOut); // R5
  AST_IRQ_HAS_IDENT: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (identCode[0] == 1'b0)); // R6
  AST_POP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rxPop |=> !rxPop); // R9
endmodule

// File: rtl/dual_uart_hostif.sv
module dual_uart_hostif
  import dual_uart_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int FIFO_DEPTH = 32,
  parameter int SYNC_ST    = 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          csN,
  input  logic [REG_ADDR_W-1:0]      regAddr,
  input  logic                       rdN,
  input  logic                       wrN,
  input  logic [BYTE_W-1:0]          busIn,
  output logic [BYTE_W-1:0]          busOut,
  output logic                       busOe,
  input  logic [NUM_CH*BYTE_W-1:0]   rxByte,
  input  logic [NUM_CH*LVL_W-1:0]    rxLevel,
  input  logic [NUM_CH*COND_W-1:0]   intCond,
  output logic [NUM_CH-1:0]          irqOut,
  output logic [NUM_CH-1:0]          irqOe,
  output logic [NUM_CH-1:0]          op2Out,
  output logic [NUM_CH-1:0]          rxRdyN,
  output logic [NUM_CH-1:0]          rxPop,
  output logic [NUM_CH-1:0]          txPush,
  output logic [BYTE_W-1:0]          txByte
);
  busStrobe_t [NUM_CH-1:0] chStrobe;
  logic [BYTE_W-1:0]       chRdData [NUM_CH];

  uart_bus_ctrl #(.NUM_CH(NUM_CH), .SYNC_ST(SYNC_ST)) ctrl_i (
    .clk(clk), .rst(rst), .csN(csN), .regAddr(regAddr),
    .rdN(rdN), .wrN(wrN), .busIn(busIn), .chStrobe(chStrobe)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic       dmaBlock;
    logic [1:0] trigSel;

    uart_chan_regs regs_i (
      .clk(clk), .rst(rst), .strobe(chStrobe[ch]),
      .rxByte(rxByte[ch*BYTE_W +: BYTE_W]),
      .intCond(intCond[ch*COND_W +: COND_W]),
      .rdData(chRdData[ch]), .irqOut(irqOut[ch]), .irqOe(irqOe[ch]),
      .op2Out(op2Out[ch]), .rxPop(rxPop[ch]), .txPush(txPush[ch]),
      .dmaBlock(dmaBlock), .trigSel(trigSel)
    );

    uart_rx_ready #(.LVL_W(LVL_W)) rdy_i (
      .clk(clk), .rst(rst), .rxLevel(rxLevel[ch*LVL_W +: LVL_W]),
      .dmaBlock(dmaBlock), .trigSel(trigSel), .rxRdyN(rxRdyN[ch])
    );
  end

  // Lowest-numbered selected channel owns the read bus
  always_comb begin
    busOut = '0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (!csN[ch]) busOut = chRdData[ch];
    end
  end

  assign busOe  = ~rdN & ~(&csN);
  assign txByte = chStrobe[0].wrData;

  AST_BUS_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (&csN) |-> !busOe); // R3
  AST_NO_STROBE_WITHOUT_SELECT: assert property (@(posedge clk) disable iff (rst)
    (&csN) |-> (rxPop == '0 && txPush == '0)); // R1
endmodule

// File: tb/dual_uart_hostif_tb.sv
module dual_uart_hostif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int LW  = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] csN = '1;
  logic [2:0]     regAddr = '0;
  logic           rdN = 1'b1;
  logic           wrN = 1'b1;
  logic [7:0]     busIn = '0;
  logic [7:0]     busOut;
  logic           busOe;
  logic [NCH*8-1:0]  rxByte = '0;
  logic [NCH*LW-1:0] rxLevel = '0;
  logic [NCH*4-1:0]  intCond = '0;
  logic [NCH-1:0] irqOut, irqOe, op2Out, rxRdyN, rxPop, txPush;
  logic [7:0]     txByte;

  int checkCnt = 0;
  int failCnt  = 0;
  int popCnt [NCH];
  int pushCnt[NCH];
  logic [7:0] lastPush;
  bit finished = 0;

  dual_uart_hostif dut_i (
    .clk(clk), .rst(rst), .csN(csN), .regAddr(regAddr), .rdN(rdN), .wrN(wrN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .rxByte(rxByte),
    .rxLevel(rxLevel), .intCond(intCond), .irqOut(irqOut), .irqOe(irqOe),
    .op2Out(op2Out), .rxRdyN(rxRdyN), .rxPop(rxPop), .txPush(txPush),
    .txByte(txByte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    for (int i = 0; i < NCH; i++) begin popCnt[i] = 0; pushCnt[i] = 0; end
    lastPush = '0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rxPop[i])  popCnt[i]++;
      if (txPush[i]) begin pushCnt[i]++; lastPush = txByte; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic busWrite(input logic [NCH-1:0] sel, input int a, input int d);
    @(negedge clk);
    csN = ~sel; regAddr = a[2:0]; busIn = d[7:0]; wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    repeat (2) @(negedge clk);
    csN = '1;
  endtask

  task automatic busRead(input logic [NCH-1:0] sel, input int a,
                         output logic [7:0] d, output logic oe);
    @(negedge clk);
    csN = ~sel; regAddr = a[2:0]; rdN = 1'b0;
    repeat (4) @(negedge clk);
    d = busOut; oe = busOe;
    rdN = 1'b1;
    repeat (2) @(negedge clk);
    csN = '1;
  endtask

  task automatic readCheck(input int ch, input int a, input int exp, input string tag);
    logic [7:0] d; logic oe;
    busRead(NCH'(1 << ch), a, d, oe);
    checkEq(tag, d, exp);
  endtask

  task automatic t_reset;
    checkEq("R10 irqOe after reset", irqOe, 0);
    checkEq("R10 op2Out after reset", op2Out, 3);
    checkEq("R10 irqOut after reset", irqOut, 0);
    checkEq("R10 rxRdyN empty after reset", rxRdyN, 3);
    readCheck(0, 1, 8'h00, "R10 enable reg zero");
    readCheck(1, 4, 8'h00, "R10 modem reg zero");
    readCheck(0, 2, 8'h01, "R6 ident idle");
  endtask

  task automatic t_regs;
    logic [7:0] d; logic oe;
    busWrite(2'b01, 7, 8'hA5);
    busWrite(2'b10, 7, 8'h3C);
    readCheck(0, 7, 8'hA5, "R2 scratch ch0");
    readCheck(1, 7, 8'h3C, "R1 scratch ch1 untouched by ch0 write");
    busWrite(2'b01, 1, 8'hFF);
    readCheck(0, 1, 8'h0F, "R2 enable upper bits read 0");
    busWrite(2'b01, 1, 8'h00);
    busWrite(2'b01, 3, 8'h9B);
    readCheck(0, 3, 8'h9B, "R2 line control");
    busWrite(2'b01, 5, 8'hFF);
    readCheck(0, 5, 8'h00, "R2 slot 5 reads 0");
    busWrite(2'b01, 6, 8'hFF);
    readCheck(0, 6, 8'h00, "R2 slot 6 reads 0");
    busRead(2'b11, 7, d, oe);
    checkEq("R3 both selected picks ch0", d, 8'hA5);
    checkEq("R3 busOe during read", oe, 1);
    checkEq("R3 busOe idle", busOe, 0);
  endtask

  task automatic t_noSelect;
    logic [7:0] d; logic oe;
    busWrite(2'b00, 7, 8'h77);
    readCheck(0, 7, 8'hA5, "R1 no-select write ignored ch0");
    readCheck(1, 7, 8'h3C, "R1 no-select write ignored ch1");
    busRead(2'b00, 7, d, oe);
    checkEq("R3 no busOe without select", oe, 0);
  endtask

  task automatic t_modem;
    busWrite(2'b10, 4, 8'h08);
    checkEq("R4 irqOe ch1 only", irqOe, 2'b10);
    checkEq("R4 op2Out inverse", op2Out, 2'b01);
    readCheck(1, 4, 8'h08, "R2 modem readback");
  endtask

  task automatic t_irq;
    busWrite(2'b10, 1, 8'h01);
    intCond = 8'h00;
    @(negedge clk);
    checkEq("R5 no condition no irq", irqOut, 0);
    intCond = 8'h10;
    @(negedge clk);
    checkEq("R5 rx data irq ch1", irqOut, 2'b10);
    busWrite(2'b10, 1, 8'h02);
    checkEq("R5 disabled source no irq", irqOut, 0);
    busWrite(2'b10, 1, 8'h0F);
    intCond = 8'hF0;
    readCheck(1, 2, 8'h06, "R6 error highest");
    intCond = 8'hB0;
    readCheck(1, 2, 8'h04, "R6 rx data next");
    intCond = 8'hA0;
    readCheck(1, 2, 8'h02, "R6 tx empty next");
    intCond = 8'h80;
    readCheck(1, 2, 8'h00, "R6 modem lowest");
    busWrite(2'b10, 4, 8'h00);
    checkEq("R5 drive off clears irq", irqOut, 0);
    checkEq("R4 op2Out back high", op2Out, 2'b11);
    intCond = 8'h00;
  endtask

  task automatic t_popPush;
    int p0, p1, q1;
    p0 = popCnt[0]; p1 = popCnt[1]; q1 = pushCnt[1];
    rxByte = 16'h005A;
    readCheck(0, 0, 8'h5A, "R2 receive slot data");
    checkEq("R9 one pop per read", popCnt[0] - p0, 1);
    checkEq("R1 other channel no pop", popCnt[1] - p1, 0);
    busWrite(2'b10, 0, 8'h99);
    checkEq("R9 one push per write", pushCnt[1] - q1, 1);
    checkEq("R9 push byte", lastPush, 8'h99);
    readCheck(0, 7, 8'hA5, "R9 non-data read");
    checkEq("R9 no pop on other slot", popCnt[0] - p0, 1);
  endtask

  task automatic setLevel(input int ch, input int lvl);
    @(negedge clk);
    rxLevel[ch*LW +: LW] = LW'(lvl);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_single;
    busWrite(2'b01, 2, 8'h00);
    setLevel(0, 0);
    checkEq("R7 empty not ready", rxRdyN[0], 1);
    setLevel(0, 1);
    checkEq("R7 one char ready", rxRdyN[0], 0);
    setLevel(0, 0);
  endtask

  task automatic t_block;
    busWrite(2'b01, 2, 8'h48);
    setLevel(0, 3);
    checkEq("R8 below trigger 4", rxRdyN[0], 1);
    setLevel(0, 4);
    checkEq("R8 trigger 4 reached", rxRdyN[0], 0);
    setLevel(0, 2);
    checkEq("R8 held while not empty", rxRdyN[0], 0);
    setLevel(0, 0);
    checkEq("R8 released on empty", rxRdyN[0], 1);
    setLevel(0, 1);
    checkEq("R8 rearmed waits for trigger", rxRdyN[0], 1);
    setLevel(0, 0);
    busWrite(2'b01, 2, 8'hC8);
    setLevel(0, 13);
    checkEq("R8 below trigger 14", rxRdyN[0], 1);
    setLevel(0, 14);
    checkEq("R8 trigger 14 reached", rxRdyN[0], 0);
    busWrite(2'b01, 2, 8'h88);
    setLevel(0, 0);
    setLevel(0, 7);
    checkEq("R8 below trigger 8", rxRdyN[0], 1);
    setLevel(0, 8);
    checkEq("R8 trigger 8 reached", rxRdyN[0], 0);
  endtask

  task automatic t_resetAgain;
    busWrite(2'b11, 4, 8'h08);
    checkEq("R4 both driven", irqOe, 2'b11);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    checkEq("R10 reset clears drive", irqOe, 0);
    checkEq("R10 reset op2 high", op2Out, 3);
    checkEq("R10 reset back to single rule", rxRdyN[0], 0);
    readCheck(0, 7, 8'h00, "R10 scratch cleared");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCnt++; checkCnt++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_noSelect();
    t_modem();
    t_irq();
    t_popPush();
    t_single();
    t_block();
    t_resetAgain();
    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule